// File: doc/BRIEF.md
# Bound-Tracking Successive Approximation Controller

This block runs a successive-approximation conversion with an external DAC and a one-bit comparator. It keeps two registered bounds, a low one and a high one, and always drives the DAC with their midpoint. After each new DAC code it waits a programmable number of clocks for the analog path to settle. It then samples the comparator flag, which means "input is at or above the DAC code". That flag moves one of the bounds onto the midpoint and shifts one bit into the result. After `RES_W` iterations the result register is loaded and a one-clock done pulse is issued.

The comparator flag is the only feedback the block uses. An external sample-and-hold must freeze the analog input while the search runs, so the block raises a hold request from the clock after the start strobe up to the done clock. A start strobe that arrives while a conversion is running is dropped.

Top module: `sar_bound_ctrl`

## Requirements
- R1: After reset, `busy_o`, `hold_o` and `done_o` are 0, `result_o` is 0, and `dac_code_o` is half scale, 2^(RES_W-1) (128 for 8 bits).
- R2: The first clock after an accepted start, `busy_o` is 1 and `dac_code_o` shows half scale: the midpoint of low bound 0 and high bound 2^RES_W.
- R3: When the sampled flag `cmp_ge_i` is 1, the result bit for that iteration is 1 and the low bound takes the current midpoint.
- R4: When the sampled flag is 0, the result bit is 0 and the high bound takes the current midpoint.
- R5: `dac_code_o` is always floor((low+high)/2). With an ideal comparator against a constant code V, the sequence of codes is the binary search for V and the final result equals V, over the whole range 0 to 2^RES_W-1.
- R6: After each new DAC code, the comparator is sampled only once the code has been stable for S clocks, where S is `settle_i` (0 to 15). A conversion takes exactly RES_W*(S+1) clocks from the start edge to the edge that raises `done_o`.
- R7: `hold_o` and `busy_o` are 1 from the clock after an accepted start up to the done clock. Both are 0 in the clock where `done_o` is 1.
- R8: A start strobe while `busy_o` is 1 is ignored. The running conversion keeps its timing and its result.
- R9: `done_o` is high for exactly one clock. `result_o` changes only in that clock, and it changes at the same edge that raises `done_o`.
- R10: `settle_i` is captured when a start is accepted. Changing it during a conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| settle_i | input | SET_W (4) | Settle clocks per DAC code, captured at start |
| cmp_ge_i | input | 1 | Comparator flag: input at or above the DAC code |
| dac_code_o | output | RES_W (8) | Midpoint code driven to the DAC |
| hold_o | output | 1 | Sample-and-hold freeze request |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock completion pulse |
| result_o | output | RES_W (8) | Converted code |

## Verification
A wrong bound update shows up on `dac_code_o` in the clock right after the faulty sample, because the next midpoint leaves the expected binary-search sequence at once. A wrong settle count or iteration count shows up as a shifted done edge. A premature sample reads the bench comparator's deliberately inverted unsettled output, so the result comes out wrong by the end of the same conversion. Faults in the hold, busy or done handling appear at the ports within one clock of the start or done edge.

// File: rtl/sar_bound_pkg.sv
package sar_bound_pkg;
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_CONV = 1'b1
    } phase_e;
endpackage

// File: rtl/sar_settle_ctr.sv
module sar_settle_ctr #(
    parameter int CW = 4
) (
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] reload,
    input  logic          active,
    output logic [CW-1:0] cnt_d,
    output logic          expired
);
    always_comb begin
        expired = active && (cnt_q == '0);
        cnt_d   = cnt_q;
        if (active) begin
            if (expired) cnt_d = reload;
            else         cnt_d = cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sar_bound_step.sv
module sar_bound_step #(
    parameter int BW = 9
) (
    input  logic [BW-1:0] lo_q,
    input  logic [BW-1:0] hi_q,
    input  logic          ge,
    output logic [BW-1:0] mid,
    output logic [BW-1:0] lo_d,
    output logic [BW-1:0] hi_d,
    output logic          bit_o
);
    logic [BW-1:0] sum;

    always_comb begin
        // bounds are one bit wider than the code, so the sum fits in BW
        sum   = lo_q + hi_q;
        mid   = sum >> 1;
        bit_o = ge;
        lo_d  = ge ? mid : lo_q;
        hi_d  = ge ? hi_q : mid;
    end
endmodule

// File: rtl/sar_bound_ctrl.sv
module sar_bound_ctrl #(
    parameter int RES_W = 8,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SET_W-1:0] settle_i,
    input  logic             cmp_ge_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    import sar_bound_pkg::*;

    localparam int BW = RES_W + 1;
    localparam int IW = $clog2(RES_W + 1);
    localparam logic [BW-1:0] FULL = BW'(1) << RES_W;
    localparam logic [IW-1:0] LAST = IW'(RES_W - 1);

    typedef struct packed {
        phase_e           ph;
        logic [BW-1:0]    lo;
        logic [BW-1:0]    hi;
        logic [SET_W-1:0] cnt;
        logic [SET_W-1:0] settle;
        logic [IW-1:0]    iter;
        logic [RES_W-1:0] sh;
        logic [RES_W-1:0] res;
        logic             done;
        logic             busy;
        logic             hold;
    } st_t;

    st_t st_q, st_d;

    logic [BW-1:0]    mid_w, lo_w, hi_w;
    logic             bit_w;
    logic [SET_W-1:0] cnt_w;
    logic             sample_w;

    sar_bound_step #(.BW(BW)) u_step (
        .lo_q  (st_q.lo),
        .hi_q  (st_q.hi),
        .ge    (cmp_ge_i),
        .mid   (mid_w),
        .lo_d  (lo_w),
        .hi_d  (hi_w),
        .bit_o (bit_w)
    );

    sar_settle_ctr #(.CW(SET_W)) u_settle (
        .cnt_q   (st_q.cnt),
        .reload  (st_q.settle),
        .active  (st_q.ph == PH_CONV),
        .cnt_d   (cnt_w),
        .expired (sample_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph     = PH_CONV;
                    st_d.lo     = '0;
                    st_d.hi     = FULL;
                    st_d.cnt    = settle_i;
                    st_d.settle = settle_i;
                    st_d.iter   = '0;
                    st_d.sh     = '0;
                    st_d.busy   = 1'b1;
                    st_d.hold   = 1'b1;
                end
            end
            PH_CONV: begin
                st_d.cnt = cnt_w;
                if (sample_w) begin
                    st_d.lo = lo_w;
                    st_d.hi = hi_w;
                    st_d.sh = {st_q.sh[RES_W-2:0], bit_w};
                    if (st_q.iter == LAST) begin
                        st_d.res  = {st_q.sh[RES_W-2:0], bit_w};
                        st_d.done = 1'b1;
                        st_d.busy = 1'b0;
                        st_d.hold = 1'b0;
                        st_d.ph   = PH_IDLE;
                    end else begin
                        st_d.iter = st_q.iter + 1'b1;
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ph     <= PH_IDLE;
            st_q.hi     <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code_o = mid_w[RES_W-1:0];
    assign hold_o     = st_q.hold;
    assign busy_o     = st_q.busy;
    assign done_o     = st_q.done;
    assign result_o   = st_q.res;
endmodule

// File: rtl/sar_bound_chk.sv
module sar_bound_chk #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [RES_W-1:0] dac_code_o,
    input logic             hold_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o
);
    localparam logic [RES_W-1:0] HALF = RES_W'(1) << (RES_W - 1);

    AST_START_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && dac_code_o == HALF)); // R2
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> hold_o); // R7
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !hold_o)); // R7
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R8
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R9
endmodule

bind sar_bound_ctrl sar_bound_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dac_code_o (dac_code_o),
    .hold_o     (hold_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/tb_sar_bound_ctrl.sv
`timescale 1ns/1ps
module tb_sar_bound_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [3:0]   settle_i = '0;
    logic         cmp_ge_i;
    logic [N-1:0] dac_code_o, result_o;
    logic         hold_o, busy_o, done_o;

    int tests = 0;
    int fails = 0;
    int vin = 0;
    int s_cur = 0;
    int stable = 100;
    logic [N-1:0] prev_code = '0;

    always #5 clk = ~clk;

    sar_bound_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
        .cmp_ge_i(cmp_ge_i), .dac_code_o(dac_code_o), .hold_o(hold_o),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    // comparator model: gives the inverted answer until the code has settled
    always @(negedge clk) begin
        if (dac_code_o != prev_code) stable <= 0;
        else if (stable < 100) stable <= stable + 1;
        prev_code <= dac_code_o;
    end
    always_comb begin
        if ((dac_code_o != prev_code) ? (s_cur == 0) : (stable >= s_cur))
            cmp_ge_i = (vin >= int'(dac_code_o));
        else
            cmp_ge_i = !(vin >= int'(dac_code_o));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // runs one conversion; restart_at >= 0 pulses start again at that clock,
    // new_settle (>=0) changes settle_i right after start
    task automatic convert(input int v, input int s, input int restart_at,
                           input int new_settle);
        int lo = 0;
        int hi = 1 << N;
        int m;
        int n = 0;
        int k = 0;
        int bad_busy = 0;
        int bad_code = 0;
        int first_code = -1;
        int lat = N * (s + 1);
        logic [N-1:0] old_res;
        @(negedge clk);
        vin = v; s_cur = s; settle_i = 4'(s); start_i = 1'b1;
        old_res = result_o;
        @(negedge clk);
        start_i = 1'b0;
        if (new_settle >= 0) settle_i = 4'(new_settle);
        first_code = int'(dac_code_o);
        check(busy_o == 1'b1, "R2", int'(busy_o), 1);
        while (!done_o && n < 400) begin
            if (!(busy_o && hold_o)) bad_busy++;
            if (result_o != old_res) bad_code++;
            if (n % (s + 1) == 0 && k < N) begin
                m = (lo + hi) / 2;
                if (int'(dac_code_o) != m) bad_code++;
                if (v >= m) lo = m; else hi = m;
                k++;
            end
            start_i = (n == restart_at);
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        check(first_code == (1 << (N - 1)), "R2", first_code, 1 << (N - 1));
        check(bad_code == 0, "R5", bad_code, 0);
        check(bad_busy == 0, "R7", bad_busy, 0);
        check(n == lat, (restart_at >= 0) ? "R8" : (new_settle >= 0 ? "R10" : "R6"), n, lat);
        check(int'(result_o) == v, (v >= 128) ? "R3" : "R4", int'(result_o), v);
        check(!busy_o && !hold_o, "R7", int'(busy_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R9", int'(done_o), 0);
        check(int'(result_o) == v, "R9", int'(result_o), v);
        settle_i = '0;
    endtask

    task automatic t_reset();
        check(!busy_o && !hold_o && !done_o, "R1", int'({busy_o, hold_o, done_o}), 0);
        check(result_o == '0, "R1", int'(result_o), 0);
        check(int'(dac_code_o) == 128, "R1", int'(dac_code_o), 128);
    endtask

    task automatic t_range();
        convert(186, 0, -1, -1); // R5 example code
        convert(0, 0, -1, -1);   // R4 all zeros
        convert(255, 0, -1, -1); // R3 all ones
        convert(128, 1, -1, -1); // R3 boundary
        convert(127, 1, -1, -1); // R4 boundary
        convert(85, 0, -1, -1);
        convert(170, 0, -1, -1);
    endtask

    task automatic t_settle();
        convert(93, 3, -1, -1);  // R6
        convert(201, 15, -1, -1); // R6 maximum settle
    endtask

    task automatic t_restart();
        convert(100, 2, 5, -1);  // R8
        convert(37, 0, 3, -1);   // R8
    endtask

    task automatic t_settle_change();
        convert(222, 3, -1, 0);  // R10
        convert(14, 0, -1, 7);   // R10
    endtask

    task automatic t_sweep();
        for (int v = 0; v < 256; v += 17) convert(v, 0, -1, -1); // R5
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_range();
                t_settle();
                t_restart();
                t_settle_change();
                t_sweep();
            end
            begin
                repeat (100000) @(posedge clk);
                fails++;
                tests++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule